// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Sequencer

This block turns a single read request from a processor core into a complete read cycle on an external bus. On that bus the low address bits and the data share one set of lines. The core presents a 20-bit address. The sequencer then steps through four fixed clock states. In the first state it puts the address out and pulses an address strobe, so an external latch can hold the address. In the second state it lets go of the shared lines, asserts an active-low read strobe and sets the transceiver to receive. In the third state it samples a ready input and adds one wait clock for each low sample. In the fourth state it captures the returned data.

The shared lines appear as three separate vectors: an output, an output enable and an input. Data and a one-clock done pulse go back to the core in the clock after the fourth state. During that same clock the bus is released again. While a cycle is in flight, a busy output tells the core to hold its requests. Any request made while busy is dropped.

Top module: `mux_rd_seq`

## Requirements
- R1: After reset and when idle: busy=0, done=0, mux_oe=0, alatch=0, rstrb_n=1, xcvr_en=0, xcvr_tx=1.
- R2: A request (req_valid=1) sampled at a clock edge while idle starts the first state (T1) in the next clock. busy is 1 from T1 through the fourth state (T4).
- R3: In T1, mux_oe=1, mux_out=req_addr[15:0] and addr_hi=req_addr[19:16]. alatch is 1 in T1 and in no other clock.
- R4: In T2, mux_oe=0, rstrb_n=0, xcvr_tx=0 (receive) and xcvr_en=1. rstrb_n stays 0 through T3, any wait clocks and T4.
- R5: bus_rdy is sampled at the end of T3 and at the end of each wait clock. Each low sample adds exactly one wait clock before T4, so a cycle with N low samples keeps busy high for 4+N clocks.
- R6: During T3, during every wait clock and during T4, the controls hold steady: rstrb_n=0, xcvr_en=1, xcvr_tx=0, mux_oe=0.
- R7: mux_in is captured at the edge that ends T4. It appears on rd_data in the following clock, which is the only clock with done=1. rd_data then holds until the next done.
- R8: A request raised while busy is ignored. No T1 (alatch pulse) follows the cycle unless a new request arrives while idle.
- R9: In the clock after T4, rstrb_n=1, xcvr_en=0, xcvr_tx=1 and busy=0, which leaves the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request from the core |
| req_addr | input | 20 | Read address |
| busy | output | 1 | Cycle in progress; requests ignored |
| done | output | 1 | One-clock pulse, rd_data valid |
| rd_data | output | 16 | Captured read data |
| mux_out | output | 16 | Shared lines, driven value |
| mux_oe | output | 1 | Shared lines, drive enable |
| mux_in | input | 16 | Shared lines, sampled value |
| addr_hi | output | 4 | Upper address bits |
| alatch | output | 1 | Address latch strobe |
| rstrb_n | output | 1 | Read strobe, active low |
| xcvr_tx | output | 1 | Transceiver direction, 1 transmit, 0 receive |
| xcvr_en | output | 1 | Transceiver enable |
| bus_rdy | input | 1 | Ready from the addressed device |

## Verification
The bus controls are decoded straight from the state register, so a wrong state shows at the ports in the same clock. A skipped or repeated state changes the alatch or strobe pattern at once. A miscounted wait changes the busy length by exactly the error. Data captured in the wrong clock picks up the filler value that the bench drives while the transceiver is off, so it shows in rd_data at the done pulse.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic busy;
        logic oe;
        logic strobe;
        logic rd_n;
        logic tx;
        logic en;
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_for(bus_state_e s);
        bus_ctl_t c;
        c = '{busy: 1'b0, oe: 1'b0, strobe: 1'b0, rd_n: 1'b1, tx: 1'b1, en: 1'b0};
        case (s)
            ST_T1: begin
                c.busy   = 1'b1;
                c.oe     = 1'b1;
                c.strobe = 1'b1;
            end
            ST_T2, ST_T3, ST_TW, ST_T4: begin
                c.busy = 1'b1;
                c.rd_n = 1'b0;
                c.tx   = 1'b0;
                c.en   = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic is_sample_state(bus_state_e s);
        return (s == ST_T3) || (s == ST_TW);
    endfunction

endpackage

// File: rtl/mrs_fsm.sv
module mrs_fsm
    import mrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       bus_rdy,
    output bus_state_e state
);
    bus_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (req_valid) nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3,
            ST_TW:   nxt = bus_rdy ? ST_T4 : ST_TW;
            ST_T4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid) |=> (state == ST_T1));

    // R5
    wait_step_chk: assert property (@(posedge clk) disable iff (rst)
        (is_sample_state(state) && !bus_rdy) |=> (state == ST_TW));
endmodule

// File: rtl/mrs_addr_drv.sv
module mrs_addr_drv
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] mux_out,
    output logic [HI_W-1:0]   addr_hi
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (state == ST_IDLE && req_valid)
            addr_q <= req_addr;
    end

    always_comb begin
        mux_out = '0;
        addr_hi = '0;
        if (state == ST_T1) begin
            mux_out = addr_q[DATA_W-1:0];
            addr_hi = addr_q[ADDR_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/mrs_capture.sv
module mrs_capture
    import mrs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic [DATA_W-1:0] mux_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= (state == ST_T4);
            if (state == ST_T4)
                rd_data <= mux_in;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && $past(!done)) |-> $stable(rd_data));
endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mux_out,
    output logic              mux_oe,
    input  logic [DATA_W-1:0] mux_in,
    output logic [HI_W-1:0]   addr_hi,
    output logic              alatch,
    output logic              rstrb_n,
    output logic              xcvr_tx,
    output logic              xcvr_en,
    input  logic              bus_rdy
);
    bus_state_e state;
    bus_ctl_t   ctl;

    mrs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_rdy   (bus_rdy),
        .state     (state)
    );

    mrs_addr_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .mux_out   (mux_out),
        .addr_hi   (addr_hi)
    );

    mrs_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .mux_in  (mux_in),
        .rd_data (rd_data),
        .done    (done)
    );

    assign ctl     = ctl_for(state);
    assign busy    = ctl.busy;
    assign mux_oe  = ctl.oe;
    assign alatch  = ctl.strobe;
    assign rstrb_n = ctl.rd_n;
    assign xcvr_tx = ctl.tx;
    assign xcvr_en = ctl.en;

    // R3
    strobe_drive_chk: assert property (@(posedge clk) disable iff (rst)
        alatch |-> mux_oe);

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        alatch |=> !alatch);

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !rstrb_n |-> (!mux_oe && xcvr_en && !xcvr_tx));

    // R4
    strobe_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rstrb_n) |-> $past(alatch));

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rstrb_n && !bus_rdy && $past(!rstrb_n)) |=> (!rstrb_n && xcvr_en));

    // R8
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !alatch);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rstrb_n && !xcvr_en && xcvr_tx && !busy));
endmodule

// File: tb/tb_mux_rd_seq.sv
`timescale 1ns/1ps
module tb_mux_rd_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        busy, done, mux_oe, alatch, rstrb_n, xcvr_tx, xcvr_en;
    logic [15:0] rd_data, mux_out, mux_in;
    logic [3:0]  addr_hi;
    logic        bus_rdy;

    int          wait_n = 0;
    logic [15:0] data_v = 16'h0;
    int          low_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    mux_rd_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .done(done), .rd_data(rd_data), .mux_out(mux_out),
        .mux_oe(mux_oe), .mux_in(mux_in), .addr_hi(addr_hi), .alatch(alatch),
        .rstrb_n(rstrb_n), .xcvr_tx(xcvr_tx), .xcvr_en(xcvr_en), .bus_rdy(bus_rdy)
    );

    // slow device model: ready after wait_n low samples
    always @(posedge clk) low_cnt <= rstrb_n ? 0 : low_cnt + 1;
    assign bus_rdy = rstrb_n ? 1'b1 : (low_cnt > wait_n);
    assign mux_in  = xcvr_en ? data_v : 16'hDEAD;

    function automatic int exp_len(input int nw);
        return 4 + nw;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_read(input logic [19:0] a, input logic [15:0] d, input int nw, input bit poke);
        int cnt;
        wait_n = nw;
        data_v = d;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        if (poke) req_addr = ~a; else req_valid = 1'b0;
        // T1
        check(mux_oe && alatch && busy, "R2/R3 T1 controls", {busy, mux_oe, alatch}, 3'b111);
        check(mux_out == a[15:0], "R3 low address", mux_out, a[15:0]);
        check(addr_hi == a[19:16], "R3 high address", addr_hi, a[19:16]);
        @(negedge clk);
        // T2
        check(!mux_oe && !rstrb_n && !xcvr_tx && xcvr_en && !alatch, "R4 T2 controls",
              {mux_oe, rstrb_n, xcvr_tx, xcvr_en, alatch}, 5'b00010);
        cnt = 2;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) break;
            cnt++;
            check(!rstrb_n && xcvr_en && !xcvr_tx && !mux_oe && !alatch && busy,
                  "R6 held controls", {rstrb_n, xcvr_en, xcvr_tx, mux_oe, alatch, busy}, 6'b010001);
        end
        req_valid = 1'b0;
        check(done, "R7 done seen", done, 1);
        check(cnt == exp_len(nw), "R5 cycle length", cnt, exp_len(nw));
        check(rd_data == d, "R7 read data", rd_data, d);
        check(rstrb_n && !xcvr_en && xcvr_tx && !busy, "R9 release",
              {rstrb_n, xcvr_en, xcvr_tx, busy}, 4'b1010);
        @(negedge clk);
        check(!done, "R7 done one clock", done, 0);
        check(rd_data == d, "R7 data held", rd_data, d);
        if (poke)
            check(!alatch && !busy, "R8 busy request ignored", {alatch, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mux_oe && !alatch && rstrb_n && !xcvr_en && xcvr_tx,
              "R1 reset state", {busy, done, mux_oe, alatch, rstrb_n, xcvr_en, xcvr_tx}, 7'b0000101);
        // directed corners
        run_read(20'h00000, 16'h1234, 0, 1'b0);
        run_read(20'hFFFFF, 16'hFFFF, 1, 1'b0);
        run_read(20'hA5C3E, 16'h0000, 12, 1'b0);
        run_read(20'h5A3C1, 16'hBEEF, 3, 1'b1);
        run_read(20'h12345, 16'h8001, 0, 1'b1);
        // random
        for (int k = 0; k < 40; k++) begin
            logic [19:0] a;
            logic [15:0] d;
            int          nw;
            a  = 20'($urandom);
            d  = 16'($urandom);
            nw = int'($urandom_range(0, 7));
            run_read(a, d, nw, ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 1) == 1) begin
                @(negedge clk);
                check(!busy && !alatch, "R1 idle gap", {busy, alatch}, 0);
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule